// File: doc/BRIEF.md
# Debug link mode selection detector

A debug port can share one data/control wire between two signalling schemes: the four-wire JTAG scan protocol and the two-wire Serial Wire Debug (SWD) protocol. This block watches that shared line and decides which scheme is active. It samples the line once per rising edge of the debug clock. It waits for a qualifying run of consecutive high samples. The first low sample after that run starts a 16-bit selection word, which is received least significant bit first. When the word is one of the recognised codes, the block updates its mode output and raises a one-cycle strobe.

The downstream TAP controller and SWD packet engine use the mode output to decide which of them owns the line. The run of high samples that the host sends after a selection word resets both engines. To this detector that run is an ordinary run of ones. Parameters can lock out either mode and can drop acceptance of the older pair of selection codes.

Top module: `dbg_link_sel`

## Requirements
- R1: While reset is asserted and after it is released, `mode_o` is 0 (JTAG) and `sel_stb_o` is 0.
- R2: After a qualifying run, the word 0xE79E (bit 0 received first) sets `mode_o` to 1 (SWD).
- R3: After a qualifying run, the word 0xE73C (bit 0 received first) sets `mode_o` to 0 (JTAG).
- R4: With `ACCEPT_OLD` set, the older word 0xEDB6 selects SWD and the older word 0xDEAE selects JTAG.
- R5: A run qualifies when it has at least `RUN_LEN` (default 50) consecutive high samples. Longer runs also qualify. Any low sample ends the run and restarts the count. Capture of a word starts at the first low sample after a qualifying run.
- R6: A captured word that matches no enabled code changes nothing and raises no strobe. The detector then needs a fresh qualifying run before it will capture another word.
- R7: The mode changes and the strobe rises in the cycle right after the clock edge that samples bit 15 of the word. The mode never changes in a cycle without the strobe.
- R8: The strobe lasts exactly one cycle. It is raised for every accepted word, including one that selects the mode already in force.
- R9: A word that selects a mode disabled by `EN_SWD` or `EN_JTAG` is ignored: the mode is kept and no strobe is raised.
- R10: A run of high samples that follows a word leaves the mode unchanged and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sampled shared data/mode-select line |
| mode_o | output | 1 | Selected link mode: 0 JTAG, 1 SWD |
| sel_stb_o | output | 1 | One-cycle pulse when a selection word is accepted |

## Verification
Internal faults in this block show up at the ports in one of two ways:
- **Broken run counter or capture phase.** If the run counter or the capture phase is wrong, a word is accepted that should be refused, or refused when it should be accepted. This shows on `mode_o` and `sel_stb_o` in the cycle right after the sixteenth bit.
- **Misaligned shift register.** If the shift register is misaligned, none of the four codes matches, so the result is a missing strobe. A bit-order slip in the other direction would make the wrong code match instead.

The bench therefore samples the outputs in four places:
- just before the deciding edge,
- just after the deciding edge,
- one cycle after that,
- across every cycle in which no strobe is expected.

The second instance locks out SWD. It exposes any leak past the mode-enable gating on the very pattern that would otherwise succeed.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic {
        LINK_JTAG = 1'b0,
        LINK_SWD  = 1'b1
    } link_mode_e;

    typedef enum logic {
        PH_HUNT    = 1'b0,
        PH_CAPTURE = 1'b1
    } phase_e;

    localparam int unsigned SEL_W = 16;

    localparam logic [SEL_W-1:0] SEL_SWD_NEW  = 16'hE79E;
    localparam logic [SEL_W-1:0] SEL_JTAG_NEW = 16'hE73C;
    localparam logic [SEL_W-1:0] SEL_SWD_OLD  = 16'hEDB6;
    localparam logic [SEL_W-1:0] SEL_JTAG_OLD = 16'hDEAE;

endpackage

// File: rtl/dls_run_counter.sv
// Counts consecutive high samples, saturating once the run qualifies.
module dls_run_counter #(
    parameter int unsigned RUN_LEN = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic hold_i,
    output logic armed_o
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(RUN_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_st_t;

    run_st_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (hold_i || !bit_i) begin
            run_d.cnt = '0;
        end else if (run_q.cnt != CNT_TOP) begin
            run_d.cnt = run_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign armed_o = (run_q.cnt == CNT_TOP);

endmodule

// File: rtl/dls_shift.sv
// Collects a selection word, first bit landing in bit 0.
module dls_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic         last_o
);
    localparam int unsigned CNTW = $clog2(W);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(W - 1);

    typedef struct packed {
        logic [W-2:0]    sh;
        logic [CNTW-1:0] cnt;
    } sh_st_t;

    sh_st_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.sh  = {bit_i, sh_q.sh[W-2:1]};
            sh_d.cnt = CNTW'(1);
        end else if (shift_i) begin
            sh_d.sh  = {bit_i, sh_q.sh[W-2:1]};
            sh_d.cnt = (sh_q.cnt == CNT_LAST) ? '0 : sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word_o = {bit_i, sh_q.sh};
    assign last_o = (sh_q.cnt == CNT_LAST);

endmodule

// File: rtl/dls_match.sv
// Decodes a complete word into a gated mode request.
module dls_match
    import dls_pkg::*;
#(
    parameter bit EN_SWD     = 1'b1,
    parameter bit EN_JTAG    = 1'b1,
    parameter bit ACCEPT_OLD = 1'b1
) (
    input  logic [SEL_W-1:0] word_i,
    output logic             swd_hit_o,
    output logic             jtag_hit_o
);
    logic swd_old, jtag_old;

    generate
        if (ACCEPT_OLD) begin : g_old
            assign swd_old  = (word_i == SEL_SWD_OLD);
            assign jtag_old = (word_i == SEL_JTAG_OLD);
        end else begin : g_no_old
            assign swd_old  = 1'b0;
            assign jtag_old = 1'b0;
        end
    endgenerate

    assign swd_hit_o  = EN_SWD  && ((word_i == SEL_SWD_NEW)  || swd_old);
    assign jtag_hit_o = EN_JTAG && ((word_i == SEL_JTAG_NEW) || jtag_old);

endmodule

// File: rtl/dbg_link_sel.sv
// Watches the shared line and selects the debug signalling mode.
module dbg_link_sel
    import dls_pkg::*;
#(
    parameter int unsigned RUN_LEN    = 50,
    parameter bit          EN_SWD     = 1'b1,
    parameter bit          EN_JTAG    = 1'b1,
    parameter bit          ACCEPT_OLD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic mode_o,
    output logic sel_stb_o
);
    typedef struct packed {
        phase_e     phase;
        link_mode_e mode;
        logic       stb;
    } top_st_t;

    localparam top_st_t TOP_RST = '{phase: PH_HUNT, mode: LINK_JTAG, stb: 1'b0};

    top_st_t st_d, st_q;

    logic             armed_w;
    logic             cap_w;
    logic             load_w;
    logic             last_w;
    logic [SEL_W-1:0] word_w;
    logic             swd_hit_w;
    logic             jtag_hit_w;

    assign cap_w  = (st_q.phase == PH_CAPTURE);
    assign load_w = (st_q.phase == PH_HUNT) && !line_i && armed_w;

    dls_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (line_i),
        .hold_i  (cap_w),
        .armed_o (armed_w)
    );

    dls_shift #(.W(SEL_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .shift_i (cap_w),
        .bit_i   (line_i),
        .word_o  (word_w),
        .last_o  (last_w)
    );

    dls_match #(
        .EN_SWD     (EN_SWD),
        .EN_JTAG    (EN_JTAG),
        .ACCEPT_OLD (ACCEPT_OLD)
    ) u_match (
        .word_i     (word_w),
        .swd_hit_o  (swd_hit_w),
        .jtag_hit_o (jtag_hit_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (load_w) begin
            st_d.phase = PH_CAPTURE;
        end else if (cap_w && last_w) begin
            st_d.phase = PH_HUNT;
            if (swd_hit_w) begin
                st_d.mode = LINK_SWD;
                st_d.stb  = 1'b1;
            end else if (jtag_hit_w) begin
                st_d.mode = LINK_JTAG;
                st_d.stb  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TOP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign sel_stb_o = st_q.stb;

endmodule

// File: rtl/dbg_link_sel_chk.sv
module dbg_link_sel_chk #(
    parameter bit EN_SWD  = 1'b1,
    parameter bit EN_JTAG = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic line_i,
    input logic mode_i,
    input logic stb_i,
    input logic cap_i,
    input logic last_i,
    input logic armed_i
);
    // R1: outputs at their reset values in the first cycle after release
    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_i == 1'b0) && !stb_i);

    // R7: the mode moves only together with the strobe
    assert_mode_moves_with_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_i) |-> stb_i);

    // R7: a strobe follows the edge that took the last word bit
    assert_stb_after_last_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |-> $past(cap_i && last_i));

    // R8: strobe is a single-cycle pulse
    assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> !stb_i);

    // R5: capture only opens on a low bit after a qualifying run
    assert_capture_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_i) |-> ($past(armed_i) && !$past(line_i)));

    // R9: a locked-out SWD mode is never reached
    assert_swd_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (EN_SWD == 1'b0) |-> (mode_i == 1'b0));

    // R9: a locked-out JTAG mode is never strobed in
    assert_jtag_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (EN_JTAG == 1'b0) |-> !(stb_i && (mode_i == 1'b0)));

endmodule

bind dbg_link_sel dbg_link_sel_chk #(
    .EN_SWD  (EN_SWD),
    .EN_JTAG (EN_JTAG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (line_i),
    .mode_i  (mode_o),
    .stb_i   (sel_stb_o),
    .cap_i   (cap_w),
    .last_i  (last_w),
    .armed_i (armed_w)
);

// File: tb/dbg_link_sel_tb.sv
`timescale 1ns/1ps
module dbg_link_sel_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b1;
    logic mode_a, stb_a, mode_b, stb_b;
    logic done = 1'b0;

    int total = 0;
    int fails = 0;

    logic exp_a_q[$];
    logic exp_b_q[$];
    logic exp_mode_a = 1'b0;
    logic exp_mode_b = 1'b0;

    always #4 clk = ~clk;

    dbg_link_sel u_dut (
        .clk (clk), .rst_n (rst_n), .line_i (line),
        .mode_o (mode_a), .sel_stb_o (stb_a)
    );

    dbg_link_sel #(.EN_SWD(1'b0)) u_dut_noswd (
        .clk (clk), .rst_n (rst_n), .line_i (line),
        .mode_o (mode_b), .sel_stb_o (stb_b)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every strobe must match a queued expectation
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (stb_a) begin
                if (exp_a_q.size() == 0) chk("R8", "unexpected strobe dut", 1, 0);
                else chk("R7", "mode at strobe dut", int'(mode_a), int'(exp_a_q.pop_front()));
            end
            if (stb_b) begin
                if (exp_b_q.size() == 0) chk("R9", "unexpected strobe locked dut", 1, 0);
                else chk("R9", "mode at strobe locked dut", int'(mode_b), int'(exp_b_q.pop_front()));
            end
        end
    end

    task automatic ones(input int n);
        repeat (n) begin
            @(negedge clk);
            line = 1'b1;
        end
    endtask

    // 0 none, 1 SWD, 2 JTAG
    function automatic int classify(input logic [15:0] w);
        if (w == 16'hE79E || w == 16'hEDB6) return 1;
        if (w == 16'hE73C || w == 16'hDEAE) return 2;
        return 0;
    endfunction

    task automatic send(input logic [15:0] pat, input bit qual, input string req);
        int  sel   = classify(pat);
        bit  acc_a = qual && (sel != 0);
        bit  acc_b = qual && (sel == 2);
        logic old_a = exp_mode_a;
        logic old_b = exp_mode_b;
        if (acc_a) begin
            exp_mode_a = (sel == 1);
            exp_a_q.push_back(exp_mode_a);
        end
        if (acc_b) begin
            exp_mode_b = 1'b0;
            exp_b_q.push_back(exp_mode_b);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 15) begin
                chk("R7", "mode before deciding edge", int'(mode_a), int'(old_a));
                chk("R7", "strobe before deciding edge", int'(stb_a), 0);
            end
            line = pat[i];
        end
        @(negedge clk);
        line = 1'b0;
        chk(req, "strobe after word", int'(stb_a), int'(acc_a));
        chk(req, "mode after word", int'(mode_a), int'(exp_mode_a));
        chk("R9", "strobe locked dut", int'(stb_b), int'(acc_b));
        chk("R9", "mode locked dut", int'(mode_b), int'(exp_mode_b));
        if (old_b != exp_mode_b) chk("R9", "locked mode moved", 1, 0);
        @(negedge clk);
        line = 1'b0;
        chk("R8", "strobe one cycle later", int'(stb_a), 0);
        chk("R8", "mode held one cycle later", int'(mode_a), int'(exp_mode_a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "mode in reset", int'(mode_a), 0);
        chk("R1", "strobe in reset", int'(stb_a), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mode after reset", int'(mode_a), 0);
        chk("R1", "strobe after reset", int'(stb_a), 0);

        ones(50);  send(16'hE79E, 1'b1, "R2");
        ones(50);  send(16'hE73C, 1'b1, "R3");
        ones(50);  send(16'hEDB6, 1'b1, "R4");
        ones(50);  send(16'hDEAE, 1'b1, "R4");
        ones(49);  send(16'hE79E, 1'b0, "R5");
        ones(30);
        @(negedge clk); line = 1'b0;
        ones(30);  send(16'hE79E, 1'b0, "R5");
        ones(200); send(16'hE79E, 1'b1, "R5");
        ones(50);  send(16'hE79E, 1'b1, "R8");
        ones(50);  send(16'h1234, 1'b1, "R6");
        send(16'hE73C, 1'b0, "R6");
        ones(80);
        @(negedge clk);
        chk("R10", "mode after trailing run", int'(mode_a), 1);
        chk("R10", "strobe after trailing run", int'(stb_a), 0);
        ones(50);  send(16'hE73C, 1'b1, "R3");

        repeat (4) @(negedge clk);
        chk("R8", "no missing strobes dut", exp_a_q.size(), 0);
        chk("R9", "no missing strobes locked dut", exp_b_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule